// File: doc/BRIEF.md
# Interrupt Line Source Multiplexer

This block sits between the general-purpose I/O ports of a chip and its external-interrupt controller. Each port has 16 pins. Interrupt line N can be fed by pin N of any one port. A 4-bit selector picks which port feeds each line. The selectors arrive packed, four to a 32-bit configuration word, across four words. The selectors are stored elsewhere; this block only reads them.

The block looks at every pin of every port. It drives each line with the level of pin N of the selected port, and the line output is registered. A pin on a port that is not selected never reaches the line. Edge detection, masking and pending state belong to the interrupt controller that follows this block.

The pin levels and selector words are plain level signals that are sampled on every clock. There is no stream and no valid/ready handshake. Nothing is ever held off, so the block exerts no back-pressure.

Top module: `irq_line_src_mux`

## Requirements
- R1: There are 16 output lines. Line N can only carry a pin whose pin index is N. Pins with any other index never reach line N.
- R2: The selector for line N is bits [(N mod 4)*4 +: 4] of configuration word N/4. Word k occupies bits [k*32 +: 32] of `cfg_words_i`.
- R3: When the selector for line N holds a value p below 8, line N carries the level of `pin_lvl_i[p*16 + N]`.
- R4: Bits 31..16 of every configuration word have no effect on any line.
- R5: A selector value from 8 to 15 drives its line low, whatever the pin levels are.
- R6: While `rst_n` is low, every line output is low.
- R7: The outputs are registered. A change on a pin or a selector shows on the lines at the first rising clock edge after it, and not before.
- R8: Level changes on pins of ports that a line does not select leave that line unchanged.
- R9: When a selector changes, the line takes the current level of the newly selected pin at the next clock edge.
- R10: With every selector at zero, every line N follows pin N of port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Outputs update on the rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. Clears all lines. |
| pin_lvl_i | input | 128 | Levels of all port pins. Bit port*16+pin. |
| cfg_words_i | input | 128 | Four selector words. Word k is at bits [k*32 +: 32]. |
| line_lvl_o | output | 16 | Registered interrupt line levels. Bit N is line N. |

## Verification
The bench gives each line a different port. A design that mixes up the word index or the bit offset of a field would then route a pin from the wrong port. It also fills the unused upper half of each word with random bits, so a design that decodes those bits would change lines it should leave alone. It toggles pins on unselected ports while the selectors stay fixed, and it sets selectors to 8 through 15 with every pin high. A design that leaks an unselected pin, or wraps the port index, would make a line go high there. Finally, it checks each line just before a clock edge and again just after. A design with no output register, or with an extra stage, shows the new value one cycle early or one cycle late.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned PORT_PINS  = 16;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SEL_PER_WD = 4;

  // bit position of the selector for a given line inside the flat word vector
  function automatic int unsigned sel_bit_base(input int unsigned line);
    return (line / SEL_PER_WD) * WORD_W + (line % SEL_PER_WD) * SEL_W;
  endfunction
endpackage

// File: rtl/lsm_sel_unpack.sv
module lsm_sel_unpack #(
  parameter int unsigned LINES  = lsm_pkg::PORT_PINS,
  parameter int unsigned SEL_W  = lsm_pkg::SEL_W,
  parameter int unsigned WORD_W = lsm_pkg::WORD_W,
  parameter int unsigned NWORDS = (LINES + lsm_pkg::SEL_PER_WD - 1) / lsm_pkg::SEL_PER_WD
) (
  input  logic [NWORDS*WORD_W-1:0] words_i,
  output logic [LINES*SEL_W-1:0]   sel_o
);
  for (genvar n = 0; n < LINES; n++) begin : g_field
    localparam int unsigned BASE = lsm_pkg::sel_bit_base(n);
    assign sel_o[n*SEL_W +: SEL_W] = words_i[BASE +: SEL_W];
  end

  // upper half of each word is not decoded
  for (genvar w = 0; w < NWORDS; w++) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^words_i[w*WORD_W + lsm_pkg::SEL_PER_WD*SEL_W +: WORD_W - lsm_pkg::SEL_PER_WD*SEL_W];
  end
endmodule

// File: rtl/lsm_line_pick.sv
module lsm_line_pick #(
  parameter int unsigned NPORTS   = 8,
  parameter int unsigned PINS     = lsm_pkg::PORT_PINS,
  parameter int unsigned SEL_W    = lsm_pkg::SEL_W,
  parameter int unsigned LINE_IDX = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*PINS-1:0] pins_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic                   line_q
);
  localparam int unsigned IDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int unsigned COLS   = 1 << IDX_W;

  logic [COLS-1:0]  col;
  logic [IDX_W-1:0] idx;
  logic             sel_ok;
  logic             pick_d;

  // gather pin LINE_IDX of every port; pad beyond NPORTS with zero
  for (genvar p = 0; p < COLS; p++) begin : g_col
    if (p < NPORTS) begin : g_real
      assign col[p] = pins_i[p*PINS + LINE_IDX];
    end else begin : g_pad
      assign col[p] = 1'b0;
    end
  end

  assign idx    = sel_i[IDX_W-1:0];
  assign sel_ok = (32'(sel_i) < NPORTS);

  always_comb begin
    pick_d = 1'b0;
    if (sel_ok) pick_d = col[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= pick_d;
  end

  // R3 / R9: a valid selector makes the line carry that port's pin next cycle
  p_pick_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_i) < NPORTS) |=> (line_q == $past(pins_i[32'(sel_i)*PINS + LINE_IDX])));

  // R5: an out-of-range selector forces the line low next cycle
  p_bad_sel_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_i) >= NPORTS) |=> !line_q);
endmodule

// File: rtl/irq_line_src_mux.sv
module irq_line_src_mux #(
  parameter int unsigned NPORTS = 8,
  parameter int unsigned LINES  = lsm_pkg::PORT_PINS,
  parameter int unsigned SEL_W  = lsm_pkg::SEL_W,
  parameter int unsigned WORD_W = lsm_pkg::WORD_W,
  parameter int unsigned NWORDS = (LINES + lsm_pkg::SEL_PER_WD - 1) / lsm_pkg::SEL_PER_WD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*LINES-1:0]  pin_lvl_i,
  input  logic [NWORDS*WORD_W-1:0] cfg_words_i,
  output logic [LINES-1:0]         line_lvl_o
);
  logic [LINES*SEL_W-1:0] sel_flat;

  lsm_sel_unpack #(
    .LINES(LINES), .SEL_W(SEL_W), .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_unpack (
    .words_i(cfg_words_i),
    .sel_o  (sel_flat)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    lsm_line_pick #(
      .NPORTS(NPORTS), .PINS(LINES), .SEL_W(SEL_W), .LINE_IDX(n)
    ) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_i(pin_lvl_i),
      .sel_i (sel_flat[n*SEL_W +: SEL_W]),
      .line_q(line_lvl_o[n])
    );
  end

  // one full cycle out of reset before quiet-input checks apply
  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  // R6: reset holds every line low
  p_reset_low_r6: assert property (@(posedge clk)
    !rst_n |-> (line_lvl_o == '0));

  // R7 / R8: with unchanged inputs the lines do not move
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(pin_lvl_i) && $stable(cfg_words_i)) |=> $stable(line_lvl_o));
endmodule

// File: tb/irq_line_src_mux_tb_top.sv
`timescale 1ns/1ps
module irq_line_src_mux_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pin_lvl_i = '0;
  logic [127:0] cfg_words_i = '0;
  logic [15:0]  line_lvl_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [15:0] last_exp = '0;

  always #2.5 clk = ~clk;

  irq_line_src_mux dut_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin_lvl_i),
    .cfg_words_i(cfg_words_i), .line_lvl_o(line_lvl_o)
  );

  function automatic logic [15:0] model(input logic [127:0] p, input logic [127:0] c);
    logic [15:0] r;
    r = '0;
    for (int n = 0; n < 16; n++) begin
      logic [3:0] s;
      s = c[(n/4)*32 + (n%4)*4 +: 4];
      r[n] = (s < 8) ? p[s*16 + n] : 1'b0;
    end
    return r;
  endfunction

  // build words from 16 packed selectors; hi fills bits 31..16 of each word
  function automatic logic [127:0] mk_cfg(input logic [63:0] sels, input logic [63:0] hi);
    logic [127:0] c;
    for (int w = 0; w < 4; w++) begin
      c[w*32 +: 16] = sels[w*16 +: 16];
      c[w*32+16 +: 16] = hi[w*16 +: 16];
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply at falling edge, verify no early change (R7), push expectation
  task automatic drive(input logic [127:0] p, input logic [127:0] c, input string tag);
    @(negedge clk);
    pin_lvl_i = p;
    cfg_words_i = c;
    #0.5;
    check("R7 early", line_lvl_o, last_exp);
    last_exp = model(p, c);
    sb_q.push_back('{last_exp, tag});
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, line_lvl_o, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] sels;
    logic [127:0] pins;
    // R6: busy inputs under reset
    pin_lvl_i = '1;
    cfg_words_i = '0;
    repeat (3) @(posedge clk);
    #1 check("R6 reset", line_lvl_o, 16'h0000);
    @(negedge clk);
    pin_lvl_i = '0;
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R6 after release", line_lvl_o, 16'h0000);

    // R10: all selectors zero follow port 0
    drive({112'h0, 16'hA5C3}, '0, "R10 pattern a");
    drive({{7{16'hFFFF}}, 16'h0F0F}, '0, "R10 pattern b");
    drive({{7{16'h1234}}, 16'h0000}, '0, "R10 pattern c");

    // R1: only pin 5 of every port high -> only line 5 can rise
    sels = '0;
    for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'(n % 8);
    drive({8{16'h0020}}, mk_cfg(sels, '0), "R1 pin index");

    // R2 / R3: each line on a different port
    for (int k = 0; k < 8; k++) begin
      pins = {$urandom, $urandom, $urandom, $urandom};
      for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'((n + k) % 8);
      drive(pins, mk_cfg(sels, '0), "R2 R3 distinct ports");
    end

    // R4: random upper halves
    for (int k = 0; k < 6; k++) begin
      pins = {$urandom, $urandom, $urandom, $urandom};
      for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'((3*n + k) % 8);
      drive(pins, mk_cfg(sels, {$urandom, $urandom}), "R4 upper bits");
    end

    // R5: out-of-range selectors with all pins high
    for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'(8 + (n % 8));
    drive('1, mk_cfg(sels, '0), "R5 bad sel");
    sels[0 +: 4] = 4'd2;
    sels[60 +: 4] = 4'd7;
    drive('1, mk_cfg(sels, '0), "R5 mixed sel");

    // R8: toggle unselected ports, selected port 3 fixed
    for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'd3;
    pins = '0;
    pins[3*16 +: 16] = 16'hC3A5;
    drive(pins, mk_cfg(sels, '0), "R8 base");
    for (int k = 0; k < 5; k++) begin
      pins = {$urandom, $urandom, $urandom, $urandom};
      pins[3*16 +: 16] = 16'hC3A5;
      drive(pins, mk_cfg(sels, '0), "R8 unselected toggle");
      check("R8 last stable", last_exp, 16'hC3A5);
    end

    // R9: pins fixed, selectors move
    pins = {16'hFFFF, 16'h0000, 16'hAAAA, 16'h5555, 16'hF0F0, 16'h0F0F, 16'hFF00, 16'h00FF};
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n < 16; n++) sels[n*4 +: 4] = 4'(k);
      drive(pins, mk_cfg(sels, '0), "R9 sel change");
    end

    // R3: random sweep including R5 values
    for (int k = 0; k < 200; k++) begin
      pins = {$urandom, $urandom, $urandom, $urandom};
      drive(pins, {$urandom, $urandom, $urandom, $urandom}, "R3 random");
    end

    @(negedge clk);
    repeat (3) @(posedge clk);
    #1 check("R7 settled", line_lvl_o, last_exp);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule